// File: doc/BRIEF.md
# Sticky Per-Word Lock Bitmap Bank

This block keeps the lock state that a fuse-array command controller consults before touching a fuse word. Four bitmaps give one bit per fuse word: one for shadow reads, one for shadow writes, one for programming, and one read-only view of permanent locks. Each bitmap is packed into consecutive 32-bit registers. Next to them sit a small global lock register and a debug-enable register. Software reaches all of it through a single-cycle register port. The fuse controller loads permanent locks through an update port. It asks whether a word is blocked for a given operation through a combinational query port.

Software can only set lock bits, by writing ones. Every lock bit is cleared by reset and by nothing else. Word indices above the configured maximum (`MAX_INDEX`) never hold a lock, and the query port always reports them as blocked. The update port is a valid-only stream with no back-pressure: the block accepts a beat in every cycle in which `perm_upd_valid` is high, and it has no ready signal. Register reads are combinational on `reg_addr`. Register and update writes take effect at the next rising clock edge.

Top module: `lockbank_top`

## Requirements
- R1: The bitmap bases are 0x094 (shadow-read), 0x07C (shadow-write), 0x064 (program) and 0x04C (permanent view). Each bitmap spans NUM_REGS registers at base+4·r. Word index i lives in register i>>5, at bit i[4:0], and every register reads back its bits.
- R2: Writing a mask to a shadow-read, shadow-write or program register sets the bits that are one in the mask. Bits that are zero in the mask keep their value, and no register write ever clears a lock bit.
- R3: A bit whose word index is greater than MAX_INDEX never becomes set and always reads 0. A query for such an index, including any index at or above NUM_REGS·32, returns blocked = 1.
- R4: Register writes to the permanent view have no effect. A permanent bit is set only by an update beat (perm_upd_valid with perm_upd_index), and it is visible one cycle later. A register write to that view in the same cycle as a beat does not disturb the beat.
- R5: The global lock register at 0x010 keeps only bits 0 (upper region), 2 (debug setting) and 4 (programming). These bits can only be set, and every other bit reads 0.
- R6: The debug-enable register at 0x014 stores wdata[10:0]. It reads back that value with bits [31:11] at zero, and it can be overwritten with any value, including one with fewer bits set.
- R7: Once global bit 2 is set, writes to the debug-enable register are ignored.
- R8: Query op codes are 0 for shadow-read, 1 for shadow-write, 2 for program and 3 for permanent. q_blocked is combinational on q_index, q_op and the stored state. A program query is blocked by the program bit, by the permanent bit, or by global bit 4.
- R9: Reset clears all bitmaps, the global lock register and the debug-enable register. Reads of addresses that are not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for register reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| perm_upd_valid | input | 1 | Permanent-lock update beat, always accepted |
| perm_upd_index | input | IDX_W | Word index to mark as permanently locked |
| q_index | input | IDX_W | Queried word index |
| q_op | input | 2 | Queried operation code |
| q_blocked | output | 1 | Word is blocked for the queried operation |

## Verification
Two functions can act in the same cycle. An update beat into the permanent view can coincide with a software register write aimed at that same view. The bench provokes this by raising both strokes together on every other beat of an index sweep. It then reads every permanent register back and queries the swept index for all four operations. The checks pass only if the beat landed and the all-ones register write changed no bit. A second case sets the debug-lock bit and writes the debug register on the next cycle, and the bench expects the old debug value to survive.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int DBG_W  = 11;
  localparam int NKIND  = 4;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_PROG = 2'd2,
    OP_PERM = 2'd3
  } lock_op_e;

  localparam logic [ADDR_W-1:0] OFF_GLB  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_DBG  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_PERM = 12'h04C;
  localparam logic [ADDR_W-1:0] OFF_PROG = 12'h064;
  localparam logic [ADDR_W-1:0] OFF_WR   = 12'h07C;
  localparam logic [ADDR_W-1:0] OFF_RD   = 12'h094;

  // Bitmap kind k uses the same number as its query op code.
  function automatic logic [ADDR_W-1:0] kind_base(input int k);
    case (k)
      0:       kind_base = OFF_RD;
      1:       kind_base = OFF_WR;
      2:       kind_base = OFF_PROG;
      default: kind_base = OFF_PERM;
    endcase
  endfunction
endpackage

// File: rtl/lockbank_bitmap.sv
module lockbank_bitmap #(
  parameter int NUM_REGS  = 3,
  parameter int MAX_INDEX = 90,
  parameter int IDX_W     = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REGS-1:0]      wr_hit,
  input  logic [31:0]              wr_mask,
  input  logic                     upd_valid,
  input  logic [IDX_W-1:0]         upd_index,
  output logic [NUM_REGS*32-1:0]   bits
);
  localparam int NW = NUM_REGS * 32;

  function automatic logic [NW-1:0] legal_bits();
    logic [NW-1:0] m;
    for (int i = 0; i < NW; i++) m[i] = (i <= MAX_INDEX);
    return m;
  endfunction

  localparam logic [NW-1:0] LEGAL = legal_bits();

  logic [NW-1:0] set_vec;
  logic [NW-1:0] bits_q;

  always_comb begin
    set_vec = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (wr_hit[r]) set_vec[r*32 +: 32] = wr_mask;
    end
    if (upd_valid && (32'(upd_index) < NW)) set_vec[upd_index] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_q | (set_vec & LEGAL);
  end

  assign bits = bits_q;
endmodule

// File: rtl/lockbank_ctl.sv
module lockbank_ctl
  import lockbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_wr,
  input  logic             dbg_wr,
  input  logic [DBG_W-1:0] wdata_lo,
  output logic [31:0]      glb_word,
  output logic [31:0]      dbg_word
);
  // glb_q[0] upper region, glb_q[1] debug setting, glb_q[2] programming
  logic [2:0]       glb_q;
  logic [DBG_W-1:0] dbg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= '0;
      dbg_q <= '0;
    end else begin
      if (glb_wr) glb_q <= glb_q | {wdata_lo[4], wdata_lo[2], wdata_lo[0]};
      if (dbg_wr && !glb_q[1]) dbg_q <= wdata_lo;
    end
  end

  assign glb_word = {27'b0, glb_q[2], 1'b0, glb_q[1], 1'b0, glb_q[0]};
  assign dbg_word = {{(32-DBG_W){1'b0}}, dbg_q};
endmodule

// File: rtl/lockbank_top.sv
module lockbank_top
  import lockbank_pkg::*;
#(
  parameter int NUM_REGS  = 3,
  parameter int MAX_INDEX = 90,
  parameter int IDX_W     = $clog2(NUM_REGS * 32)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              perm_upd_valid,
  input  logic [IDX_W-1:0]  perm_upd_index,
  input  logic [IDX_W-1:0]  q_index,
  input  logic [1:0]        q_op,
  output logic              q_blocked
);
  localparam int NW = NUM_REGS * 32;

  logic [NW-1:0] map_bits [NKIND];
  logic [31:0]   glb_word;
  logic [31:0]   dbg_word;

  for (genvar k = 0; k < NKIND; k++) begin : g_map
    logic [NUM_REGS-1:0] hit;
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
      // The permanent view takes no register writes.
      assign hit[r] = (k != int'(OP_PERM)) && reg_wr_en &&
                      (reg_addr == kind_base(k) + ADDR_W'(4 * r));
    end
    lockbank_bitmap #(
      .NUM_REGS (NUM_REGS),
      .MAX_INDEX(MAX_INDEX),
      .IDX_W    (IDX_W)
    ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (hit),
      .wr_mask  (reg_wdata),
      .upd_valid((k == int'(OP_PERM)) ? perm_upd_valid : 1'b0),
      .upd_index(perm_upd_index),
      .bits     (map_bits[k])
    );
  end

  lockbank_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .glb_wr  (reg_wr_en && (reg_addr == OFF_GLB)),
    .dbg_wr  (reg_wr_en && (reg_addr == OFF_DBG)),
    .wdata_lo(reg_wdata[DBG_W-1:0]),
    .glb_word(glb_word),
    .dbg_word(dbg_word)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_GLB) reg_rdata = glb_word;
    if (reg_addr == OFF_DBG) reg_rdata = dbg_word;
    for (int k = 0; k < NKIND; k++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (reg_addr == kind_base(k) + ADDR_W'(4 * r))
          reg_rdata = map_bits[k][r*32 +: 32];
      end
    end
  end

  always_comb begin
    q_blocked = 1'b1;
    if (32'(q_index) <= MAX_INDEX) begin
      case (lock_op_e'(q_op))
        OP_RD:   q_blocked = map_bits[0][q_index];
        OP_WR:   q_blocked = map_bits[1][q_index];
        OP_PROG: q_blocked = map_bits[2][q_index] | map_bits[3][q_index] |
                             glb_word[4];
        default: q_blocked = map_bits[3][q_index];
      endcase
    end
  end
endmodule

// File: rtl/lockbank_chk.sv
module lockbank_chk #(
  parameter int NUM_REGS  = 3,
  parameter int MAX_INDEX = 90,
  parameter int IDX_W     = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   perm_upd_valid,
  input logic [IDX_W-1:0]       q_index,
  input logic [1:0]             q_op,
  input logic                   q_blocked,
  input logic [NUM_REGS*32-1:0] rd_bits,
  input logic [NUM_REGS*32-1:0] wr_bits,
  input logic [NUM_REGS*32-1:0] pg_bits,
  input logic [NUM_REGS*32-1:0] pm_bits,
  input logic [31:0]            glb_word,
  input logic [31:0]            dbg_word
);
  localparam int NW = NUM_REGS * 32;

  function automatic logic [NW-1:0] illegal_bits();
    logic [NW-1:0] m;
    for (int i = 0; i < NW; i++) m[i] = (i > MAX_INDEX);
    return m;
  endfunction

  localparam logic [NW-1:0] ILLEGAL = illegal_bits();

  a_r2_sticky_rd: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_bits & $past(rd_bits)) == $past(rd_bits)));
  a_r2_sticky_wr: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wr_bits & $past(wr_bits)) == $past(wr_bits)));
  a_r2_sticky_pg: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pg_bits & $past(pg_bits)) == $past(pg_bits)));
  a_r3_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_bits | wr_bits | pg_bits | pm_bits) & ILLEGAL) == '0);
  a_r3_oob_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(q_index) > MAX_INDEX) |-> q_blocked);
  a_r4_perm_only_upd: assert property (@(posedge clk) disable iff (!rst_n)
    !perm_upd_valid |=> $stable(pm_bits));
  a_r5_glb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((glb_word & $past(glb_word)) == $past(glb_word)));
  a_r7_dbg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    glb_word[2] |=> $stable(dbg_word));
  a_r8_prog_global: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_word[4] && q_op == 2'd2) |-> q_blocked);
endmodule

bind lockbank_top lockbank_chk #(
  .NUM_REGS (NUM_REGS),
  .MAX_INDEX(MAX_INDEX),
  .IDX_W    (IDX_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .perm_upd_valid(perm_upd_valid),
  .q_index       (q_index),
  .q_op          (q_op),
  .q_blocked     (q_blocked),
  .rd_bits       (map_bits[0]),
  .wr_bits       (map_bits[1]),
  .pg_bits       (map_bits[2]),
  .pm_bits       (map_bits[3]),
  .glb_word      (glb_word),
  .dbg_word      (dbg_word)
);

// File: tb/tb_lockbank_top.sv
module tb_lockbank_top;
  localparam int NR   = 3;
  localparam int MAXI = 90;
  localparam int NW   = NR * 32;
  localparam int IW   = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          perm_upd_valid = 1'b0;
  logic [IW-1:0] perm_upd_index = '0;
  logic [IW-1:0] q_index = '0;
  logic [1:0]    q_op = '0;
  logic          q_blocked;

  int checks = 0;
  int errors = 0;

  logic [NW-1:0] m [4];
  logic [31:0]   m_glb;
  logic [31:0]   m_dbg;

  always #10 clk = ~clk;

  lockbank_top #(.NUM_REGS(NR), .MAX_INDEX(MAXI)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .perm_upd_valid(perm_upd_valid), .perm_upd_index(perm_upd_index),
    .q_index(q_index), .q_op(q_op), .q_blocked(q_blocked)
  );

  function automatic logic [11:0] base(input int k);
    case (k)
      0: return 12'h094;
      1: return 12'h07C;
      2: return 12'h064;
      default: return 12'h04C;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a,
                          input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp, $sformatf("read @%h", a));
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < NR; r++)
        rd_check(req, base(k) + 12'(4 * r), m[k][r*32 +: 32]);
  endtask

  function automatic logic exp_q(input int idx, input int op);
    if (idx > MAXI) return 1'b1;
    case (op)
      0: return m[0][idx];
      1: return m[1][idx];
      2: return m[2][idx] | m[3][idx] | m_glb[4];
      default: return m[3][idx];
    endcase
  endfunction

  task automatic check_query(input int idx, input string req);
    for (int op = 0; op < 4; op++) begin
      q_index = IW'(idx); q_op = 2'(op);
      #1;
      check(req, {31'b0, q_blocked}, {31'b0, exp_q(idx, op)},
            $sformatf("query idx %0d op %0d", idx, op));
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < 4; k++) m[k] = '0;
    m_glb = '0; m_dbg = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    check_regs("R9");
    rd_check("R9", 12'h010, 32'h0);
    rd_check("R9", 12'h014, 32'h0);
    for (int i = 0; i < 128; i++) check_query(i, (i > MAXI) ? "R3" : "R8");

    // R1: single-bit sweep across the three software-set bitmaps
    for (int i = 0; i < NW; i++) begin
      int k = i % 3;
      wr(base(k) + 12'(4 * (i / 32)), 32'h1 << (i % 32));
      if (i <= MAXI) m[k][i] = 1'b1;
      rd_check((i > MAXI) ? "R3" : "R1", base(k) + 12'(4 * (i / 32)),
               m[k][(i/32)*32 +: 32]);
      check_query(i, (i > MAXI) ? "R3" : "R1");
    end

    // R2: zero masks never clear; multi-bit masks add bits
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < NR; r++) wr(base(k) + 12'(4 * r), 32'h0);
    check_regs("R2");
    wr(base(0) + 12'h8, 32'hFFFF_FFFF);
    for (int i = 64; i <= MAXI; i++) m[0][i] = 1'b1;
    wr(base(1), 32'hA5A5_0F0F);
    m[1][31:0] = m[1][31:0] | 32'hA5A5_0F0F;
    check_regs("R2");

    // R4: register writes to the permanent view are ignored
    for (int r = 0; r < NR; r++) wr(base(3) + 12'(4 * r), 32'hFFFF_FFFF);
    check_regs("R4");

    // R4: update beats, half of them colliding with a register write
    for (int i = 0; i < 128; i += 5) begin
      @(negedge clk);
      perm_upd_valid = 1'b1; perm_upd_index = IW'(i);
      if (i % 2 == 0) begin
        reg_wr_en = 1'b1; reg_addr = base(3) + 12'(4 * ((i / 32) % NR));
        reg_wdata = 32'hFFFF_FFFF;
      end
      @(negedge clk);
      perm_upd_valid = 1'b0; reg_wr_en = 1'b0;
      if (i <= MAXI) m[3][i] = 1'b1;
      check_query(i, (i > MAXI) ? "R3" : "R4");
    end
    check_regs("R4");

    // R5: only bits 0, 2, 4 exist in the global lock register
    wr(12'h010, 32'hFFFF_FFEA);
    rd_check("R5", 12'h010, 32'h0);

    // R6: debug register keeps bits [10:0] and is overwritable
    wr(12'h014, 32'hFFFF_FFFF); m_dbg = 32'h7FF;
    rd_check("R6", 12'h014, m_dbg);
    wr(12'h014, 32'h0000_0123); m_dbg = 32'h123;
    rd_check("R6", 12'h014, m_dbg);

    // R8: global programming lock blocks program queries
    wr(12'h010, 32'h10); m_glb = 32'h10;
    rd_check("R5", 12'h010, m_glb);
    for (int i = 0; i < 128; i += 3) check_query(i, "R8");

    // R7: debug lock freezes the debug register
    wr(12'h010, 32'h4); m_glb = 32'h14;
    rd_check("R5", 12'h010, m_glb);
    wr(12'h014, 32'h0000_0055);
    rd_check("R7", 12'h014, m_dbg);
    wr(12'h010, 32'h0);
    rd_check("R5", 12'h010, m_glb);
    wr(12'h010, 32'h1); m_glb = 32'h15;
    rd_check("R5", 12'h010, m_glb);

    // R9: unmapped addresses read zero
    rd_check("R9", 12'h000, 32'h0);
    rd_check("R9", 12'h018, 32'h0);
    rd_check("R9", 12'h04E, 32'h0);
    rd_check("R9", 12'h0A0, 32'h0);

    // R9: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    check_regs("R9");
    rd_check("R9", 12'h010, 32'h0);
    rd_check("R9", 12'h014, 32'h0);
    for (int i = 0; i < 128; i += 7) check_query(i, "R9");

    finish_run();
  end
endmodule